// File: doc/BRIEF.md
# Discharge-Time Sampler and Zero-Crossing Detector

This block works on the primary side of a flyback converter that runs in discontinuous conduction. Each switching cycle it times how long the secondary diode conducts, using only the gate drive and a digitized auxiliary-winding sense voltage. The timer starts when the gate turns off. During the discharge phase the sense voltage is captured once, at 85% of the conduction time measured in the previous cycle. The end of conduction is declared when the live sense voltage falls more than 200 mV below that captured value. If the gate turns back on before any such drop is seen, the measurement closes at the full off-time and is marked as a timeout.

The held voltage stands in for the output voltage. The block derives several control values from it. A hysteretic power-limit flag selects between two peak-current thresholds. A frequency-reduction value makes the converter slow down as the output sags in constant-current operation. An over-voltage flag is passed on to the protection logic. The ADC is assumed to deliver one sample per clock, in millivolts.

Top module: `dischg_zcd_sampler`

## Requirements
- R1: After reset the outputs are as follows. Discharge time 0, held voltage 0, zero-crossing pulse 0, timeout 0, power-limit flag 1, current-limit code 300, frequency reduction 57100 and over-voltage flag 0.
- R2: Call E0 the clock edge that first samples the gate low after it was high. When the measurement ends at edge E0+k, the discharge time becomes k. If the end is a zero crossing, the timeout flag becomes 0 at that same edge.
- R3: The held voltage takes the sense sample at edge E0+s, where s = max(1, (T*217)>>8) and T is the discharge time reported before E0. Outside that edge the held voltage does not change, and it is captured at most once per cycle.
- R4: A zero crossing is declared only after the capture of the current cycle. It requires a sense sample strictly more than 200 mV below the held voltage: a drop of exactly 200 mV does not end the measurement.
- R5: The zero-crossing output is high for exactly one cycle, just after the edge at which the discharge time is updated by a zero crossing, and never for a timeout.
- R6: If the gate is sampled high at edge E0+k with no zero crossing yet, the discharge time becomes k and the timeout flag becomes 1.
- R7: On capture, a held value below 550 mV sets the power-limit flag. A value above 750 mV clears it. A value from 550 to 750 mV leaves it unchanged.
- R8: The current-limit code is 300 (mV) while the power-limit flag is set, else 800.
- R9: The frequency reduction, in Hz, depends on the held voltage V. It is 0 for V > 2150. It is 2000 + 38*(2150 - V) for 700 <= V <= 2150. It is 57100 for V < 700.
- R10: The over-voltage flag is 1 exactly when the held voltage exceeds 2800 mV.
- R11: The discharge count saturates at 2^CW - 1, and a reported discharge time never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Power switch drive, 1 = on |
| vs_mv_i | input | VW | Sense voltage sample, unsigned mV |
| tdis_o | output | CW | Last discharge time, clock cycles |
| vsh_mv_o | output | VW | Held sense voltage, mV |
| zcd_o | output | 1 | One-cycle zero-crossing pulse |
| timeout_o | output | 1 | Last measurement ended at gate turn-on |
| plim_o | output | 1 | Power-limit mode flag |
| ilim_mv_o | output | ILW | Selected current-limit threshold, mV |
| fdrop_hz_o | output | FW | Constant-current frequency reduction, Hz |
| ovp_o | output | 1 | Output over-voltage flag |

## Verification
The bench builds the block with an 8-bit discharge counter, so cycles of a few hundred clocks reach saturation at 255. The following cycle then shows the 85% point derived from a saturated count (216). The 12-bit sample width and default thresholds are kept, so the vectors can place held voltages exactly on 550/750, 700/2150 and 2800 mV boundaries. Ramped plateaus make the captured value reveal the edge at which the capture happened.

// File: rtl/dzs_pkg.sv
package dzs_pkg;

  localparam int unsigned PT_NUM   = 217;
  localparam int unsigned PT_SHIFT = 8;

  typedef enum logic {PH_IDLE, PH_DISCH} phase_t;

  // 85% point of a stored count: (t*217)>>8
  function automatic logic [31:0] frac85(input logic [31:0] t);
    logic [31:0] prod;
    prod = t * PT_NUM;
    return prod >> PT_SHIFT;
  endfunction

  // Frequency reduction in Hz from held voltage (mV), clamped at both ends
  function automatic logic [31:0] cc_drop_hz(input logic [31:0] v,
                                             input logic [31:0] v_hi,
                                             input logic [31:0] v_lo,
                                             input logic [31:0] base_hz,
                                             input logic [31:0] slope_hz);
    logic [31:0] vc;
    if (v > v_hi) return 32'd0;
    vc = (v < v_lo) ? v_lo : v;
    return base_hz + slope_hz * (v_hi - vc);
  endfunction

  function automatic logic [31:0] pick_ilim(input logic plim,
                                            input logic [31:0] low_mv,
                                            input logic [31:0] norm_mv);
    return plim ? low_mv : norm_mv;
  endfunction

endpackage

// File: rtl/dzs_timer.sv
module dzs_timer
  import dzs_pkg::*;
#(
  parameter int CW      = 16,
  parameter int VW      = 12,
  parameter int DROP_MV = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_i,
  input  logic [VW-1:0] vs_i,
  input  logic [VW-1:0] vsh_i,
  output logic [CW-1:0] tdis_o,
  output logic          timeout_o,
  output logic          zcd_o,
  output logic          smp_stb_o
);

  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [VW:0]   DROPX = (VW+1)'(DROP_MV);

  phase_t        ph_q;
  logic          gate_q;
  logic          smp_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] spt_q;
  logic [CW-1:0] tdis_q;
  logic          tmo_q;
  logic          zcd_q;

  // named internal events
  logic          fall_w;
  logic          in_dis_w;
  logic          end_tmo_w;
  logic          end_zcd_w;
  logic          drop_hit_w;
  logic [VW:0]   vs_plus_w;
  logic [CW-1:0] pt_next_w;

  assign fall_w     = gate_q & ~gate_i;
  assign in_dis_w   = (ph_q == PH_DISCH);
  assign vs_plus_w  = {1'b0, vs_i} + DROPX;
  assign drop_hit_w = smp_q && (vs_plus_w < {1'b0, vsh_i});
  assign end_tmo_w  = in_dis_w && gate_i;
  assign end_zcd_w  = in_dis_w && !gate_i && drop_hit_w;
  assign smp_stb_o  = in_dis_w && !gate_i && !smp_q && (cnt_q == spt_q);
  assign pt_next_w  = CW'(frac85(32'(tdis_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      gate_q <= 1'b0;
      smp_q  <= 1'b0;
      cnt_q  <= '0;
      spt_q  <= '0;
      tdis_q <= '0;
      tmo_q  <= 1'b0;
      zcd_q  <= 1'b0;
    end else begin
      gate_q <= gate_i;
      zcd_q  <= end_zcd_w;
      if (fall_w) begin
        ph_q  <= PH_DISCH;
        cnt_q <= CW'(1);
        smp_q <= 1'b0;
        spt_q <= (pt_next_w == '0) ? CW'(1) : pt_next_w;
      end else if (in_dis_w) begin
        if (end_tmo_w) begin
          ph_q   <= PH_IDLE;
          tdis_q <= cnt_q;
          tmo_q  <= 1'b1;
        end else begin
          if (end_zcd_w) begin
            ph_q   <= PH_IDLE;
            tdis_q <= cnt_q;
            tmo_q  <= 1'b0;
          end
          if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
          if (smp_stb_o) smp_q <= 1'b1;
        end
      end
    end
  end

  assign tdis_o    = tdis_q;
  assign timeout_o = tmo_q;
  assign zcd_o     = zcd_q;

  assert_zcd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zcd_q |=> !zcd_q);

  assert_zcd_not_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    zcd_q |-> !tmo_q);

  assert_timeout_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(gate_i));

  assert_count_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dis_w && cnt_q == CMAX) |=> (cnt_q == CMAX));

  assert_zcd_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_zcd_w |-> !smp_stb_o);

endmodule

// File: rtl/dzs_hold.sv
module dzs_hold #(
  parameter int VW     = 12,
  parameter int PL_IN  = 550,
  parameter int PL_OUT = 750,
  parameter int OVP_MV = 2800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic [VW-1:0] vs_i,
  output logic [VW-1:0] vsh_o,
  output logic          plim_o,
  output logic          ovp_o
);

  localparam logic [VW-1:0] PL_IN_V  = VW'(PL_IN);
  localparam logic [VW-1:0] PL_OUT_V = VW'(PL_OUT);
  localparam logic [VW-1:0] OVP_V    = VW'(OVP_MV);

  logic [VW-1:0] vsh_q;
  logic          plim_q;
  logic          enter_w;
  logic          leave_w;

  assign enter_w = vs_i < PL_IN_V;
  assign leave_w = vs_i > PL_OUT_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsh_q  <= '0;
      plim_q <= 1'b1;
    end else if (stb_i) begin
      vsh_q <= vs_i;
      if (enter_w)      plim_q <= 1'b1;
      else if (leave_w) plim_q <= 1'b0;
    end
  end

  assign vsh_o  = vsh_q;
  assign plim_o = plim_q;
  assign ovp_o  = vsh_q > OVP_V;

  assert_vsh_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(vsh_q));

  assert_plim_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vsh_q < PL_IN_V) |-> plim_q);

  assert_plim_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vsh_q > PL_OUT_V) |-> !plim_q);

endmodule

// File: rtl/dzs_cc_freq.sv
module dzs_cc_freq
  import dzs_pkg::*;
#(
  parameter int VW       = 12,
  parameter int FW       = 17,
  parameter int ILW      = 10,
  parameter int VN_MV    = 2150,
  parameter int VG_MV    = 700,
  parameter int BASE_HZ  = 2000,
  parameter int SLOPE_HZ = 38,
  parameter int ILIM_LO  = 300,
  parameter int ILIM_NRM = 800
) (
  input  logic [VW-1:0]  vsh_i,
  input  logic           plim_i,
  output logic [FW-1:0]  fdrop_o,
  output logic [ILW-1:0] ilim_o
);

  assign fdrop_o = FW'(cc_drop_hz(32'(vsh_i), 32'(VN_MV), 32'(VG_MV),
                                  32'(BASE_HZ), 32'(SLOPE_HZ)));
  assign ilim_o  = ILW'(pick_ilim(plim_i, 32'(ILIM_LO), 32'(ILIM_NRM)));

endmodule

// File: rtl/dischg_zcd_sampler.sv
module dischg_zcd_sampler #(
  parameter int CW  = 16,
  parameter int VW  = 12,
  parameter int FW  = 17,
  parameter int ILW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gate_i,
  input  logic [VW-1:0]  vs_mv_i,
  output logic [CW-1:0]  tdis_o,
  output logic [VW-1:0]  vsh_mv_o,
  output logic           zcd_o,
  output logic           timeout_o,
  output logic           plim_o,
  output logic [ILW-1:0] ilim_mv_o,
  output logic [FW-1:0]  fdrop_hz_o,
  output logic           ovp_o
);

  logic          smp_stb;
  logic [VW-1:0] vsh;
  logic          plim;

  dzs_timer #(.CW(CW), .VW(VW), .DROP_MV(200)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_i    (gate_i),
    .vs_i      (vs_mv_i),
    .vsh_i     (vsh),
    .tdis_o    (tdis_o),
    .timeout_o (timeout_o),
    .zcd_o     (zcd_o),
    .smp_stb_o (smp_stb)
  );

  dzs_hold #(.VW(VW), .PL_IN(550), .PL_OUT(750), .OVP_MV(2800)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_i  (smp_stb),
    .vs_i   (vs_mv_i),
    .vsh_o  (vsh),
    .plim_o (plim),
    .ovp_o  (ovp_o)
  );

  dzs_cc_freq #(.VW(VW), .FW(FW), .ILW(ILW)) u_freq (
    .vsh_i   (vsh),
    .plim_i  (plim),
    .fdrop_o (fdrop_hz_o),
    .ilim_o  (ilim_mv_o)
  );

  assign vsh_mv_o = vsh;
  assign plim_o   = plim;

  assert_ilim_tracks_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plim) |-> (ilim_mv_o < ILW'(800)));

endmodule

// File: tb/tb_dischg_zcd_sampler.sv
module tb_dischg_zcd_sampler;
  localparam int CW = 8, VW = 12, FW = 17, ILW = 10;
  localparam int CMAXI = (1 << CW) - 1;
  localparam int NV = 16;
  // plateau, ramp step, low value, drop edge (0 = none), off length, on length
  localparam int VEC [0:NV-1][0:5] = '{
    '{1000, 1,    0,  30,  40, 10},
    '{1000, 1,    0,  40,  60, 10},
    '{2500, 1,    0,  45,  50, 10},
    '{2790, 1,    0,  20,  60, 10},
    '{2790, 1,    0,  70,  80, 10},
    '{ 600, 1,    0,  70, 100, 10},
    '{ 400, 1,    0,  70, 100, 10},
    '{ 600, 1,    0,  70, 100, 10},
    '{1500, 0, 1300,  70, 100, 10},
    '{1500, 0, 1299,  90, 120, 10},
    '{2150, 0,    0,  80, 100, 10},
    '{2151, 0,    0,  80, 100, 10},
    '{ 700, 0,    0,  80, 100, 10},
    '{ 699, 0,    0,  80, 100, 10},
    '{1000, 0,    0,   0, 300, 10},
    '{1000, 1,    0, 230, 240, 10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate = 1'b1;
  logic [VW-1:0] vs = '0;
  logic [CW-1:0] tdis;
  logic [VW-1:0] vsh;
  logic zcd, tmo, plim, ovp;
  logic [ILW-1:0] ilim;
  logic [FW-1:0] fdrop;

  int n_run = 0, n_fail = 0;
  int m_tprev = 0, m_vsh = 0, m_plim = 1, m_tmo = 0;

  always #10 clk = ~clk;

  dischg_zcd_sampler #(.CW(CW), .VW(VW), .FW(FW), .ILW(ILW)) dut (
    .clk(clk), .rst_n(rst_n), .gate_i(gate), .vs_mv_i(vs),
    .tdis_o(tdis), .vsh_mv_o(vsh), .zcd_o(zcd), .timeout_o(tmo),
    .plim_o(plim), .ilim_mv_o(ilim), .fdrop_hz_o(fdrop), .ovp_o(ovp));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_fdrop(input int v);
    if (v > 2150) return 0;
    if (v < 700) return 2000 + 38 * 1450;
    return 2000 + (2150 - v) * 38;
  endfunction

  task automatic run_cycle(input int plat, input int step, input int low,
                           input int zat, input int off_len, input int on_len);
    int spt, vk, ev_k, zcount, zk;
    bit smp, done;
    spt = (m_tprev * 217) >> 8;
    if (spt == 0) spt = 1;
    smp = 0; done = 0; ev_k = -1; zcount = 0; zk = -1;
    for (int k = 0; k <= off_len; k++) begin
      @(negedge clk);
      if (zcd) begin zcount++; zk = k - 1; end
      vk = (zat != 0 && k >= zat) ? low : plat + step * k;
      if (vk > 4095) vk = 4095;
      gate = (k == off_len);
      vs = VW'(vk);
      if (k > 0 && !done) begin
        if (k == off_len) begin
          done = 1; m_tmo = 1; m_tprev = (k > CMAXI) ? CMAXI : k;
        end else begin
          if (smp && (vk + 200 < m_vsh)) begin
            done = 1; m_tmo = 0; ev_k = k; m_tprev = (k > CMAXI) ? CMAXI : k;
          end
          if (!smp && k == spt) begin
            smp = 1; m_vsh = vk;
            if (vk < 550) m_plim = 1;
            else if (vk > 750) m_plim = 0;
          end
        end
      end
    end
    for (int j = 0; j < on_len; j++) begin
      @(negedge clk);
      if (zcd) begin zcount++; zk = -2; end
      gate = 1'b1;
      vs = '0;
    end
    check("R5", "zcd pulse count", zcount, (ev_k >= 0) ? 1 : 0);
    if (ev_k >= 0) check("R5", "zcd pulse edge", zk, ev_k);
    check("R2", "discharge time", int'(tdis), m_tprev);
    check("R6", "timeout flag", int'(tmo), m_tmo);
    check("R3", "held voltage", int'(vsh), m_vsh);
    check("R7", "power-limit flag", int'(plim), m_plim);
    check("R8", "current-limit code", int'(ilim), m_plim ? 300 : 800);
    check("R9", "frequency reduction", int'(fdrop), exp_fdrop(m_vsh));
    check("R10", "over-voltage flag", int'(ovp), (m_vsh > 2800) ? 1 : 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "tdis", int'(tdis), 0);
    check("R1", "vsh", int'(vsh), 0);
    check("R1", "zcd", int'(zcd), 0);
    check("R1", "timeout", int'(tmo), 0);
    check("R1", "plim", int'(plim), 1);
    check("R1", "ilim", int'(ilim), 300);
    check("R1", "fdrop", int'(fdrop), 57100);
    check("R1", "ovp", int'(ovp), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NV; i++)
      run_cycle(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);
    // R4 exact 200 mV drop (vector 8) and 201 mV drop (vector 9) covered above
    // R11 saturation: vector 14 holds the off phase for 300 cycles
    check("R11", "saturated time after long cycle pair", m_tprev, 230);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule